// File: doc/BRIEF.md
# Unified Address Space Decoder

This block turns a 24-bit byte address into a target choice for a processor whose program fetches, data accesses, DMA transfers and host-port transfers all use one shared address map. For every accepted request it names exactly one target: one of the dual-port RAM banks, one of the single-port RAM banks, the memory-mapped register window, the on-chip ROM, external memory, or a host-access error. It also gives the byte offset inside that target. The memory arrays and the arbitration between requesters are outside this block.

Requests enter on a valid/ready port and leave one cycle later on a registered valid/ready port. Back-pressure works as follows. A response stays on the output, unchanged, until `rsp_ready` accepts it. `req_ready` is high only when the output register is empty or is being drained in the same cycle. A request that is not accepted is not decoded.

A software-writable ROM-disable bit sends the top 64 KB either to the on-chip ROM or to external memory. The asynchronous hardware reset clears this bit. The synchronous software reset does not change it; it only empties the output register.

Top module: `umap_decode`

## Requirements
- R1: Byte addresses 0x000C0 to 0x0FFFF select dual-port bank `addr[15:13]` on `rsp_daram_sel` (bit n = bank n), with offset `addr[12:0]`.
- R2: Byte addresses 0x00000 to 0x000BF assert `rsp_mmr_sel` instead of any RAM bank, with offset equal to the address.
- R3: Byte addresses 0x10000 to 0x1FFFF select single-port bank `addr[15:13]` on `rsp_saram_sel`, with offset `addr[12:0]`.
- R4: Byte addresses 0xFF0000 to 0xFFFFFF assert `rsp_rom_sel` with offset `addr[15:0]` while the ROM-disable bit is 0. While the bit is 1 they assert `rsp_ext_sel` with offset 0.
- R5: Every other address asserts `rsp_ext_sel` with offset 0.
- R6: Hardware reset (`rst_n` low) clears `rom_dis` at once. A cycle with `rom_dis_we` high loads `rom_dis_wdata` at that clock edge. A request accepted in that same cycle is decoded with the old value.
- R7: `sw_reset` leaves `rom_dis` unchanged. At the next edge it clears `rsp_valid`, and a request offered in the same cycle is dropped.
- R8: A request with `req_src` = 3 (host; 0 = program, 1 = data, 2 = DMA) at address 0x8000 or above asserts `rsp_host_err`, with every select low and offset 0.
- R9: While `rsp_valid` is high, exactly one of the bank selects, `rsp_rom_sel`, `rsp_mmr_sel`, `rsp_ext_sel` and `rsp_host_err` is high.
- R10: A request accepted (`req_valid && req_ready`) appears on the response port at the next edge. `req_ready` equals `!rsp_valid || rsp_ready`, and a response that is not taken is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset |
| rom_dis_we | input | 1 | Write strobe for the ROM-disable bit |
| rom_dis_wdata | input | 1 | New ROM-disable value |
| rom_dis | output | 1 | Current ROM-disable bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 24 | Byte address |
| req_src | input | 2 | Requester: 0 program, 1 data, 2 DMA, 3 host |
| rsp_valid | output | 1 | Decoded response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_daram_sel | output | 8 | One-hot dual-port bank select |
| rsp_saram_sel | output | 8 | One-hot single-port bank select |
| rsp_rom_sel | output | 1 | On-chip ROM select |
| rsp_mmr_sel | output | 1 | Register window select |
| rsp_ext_sel | output | 1 | External memory select |
| rsp_host_err | output | 1 | Host request outside its reachable banks |
| rsp_offset | output | 16 | Byte offset inside the target |

## Verification
The block holds two pieces of state: the ROM-disable bit and the output register. If the disable bit is wrong, `rom_dis` shows it in the next cycle. The next top-64 KB request then lands on the wrong target, and this shows one cycle after that request is accepted. If the output register is wrong, a select or offset that does not match the latched address shows on the same cycle the response becomes valid. A broken hold shows on the first stalled cycle. The reference model follows the disable bit across both reset kinds, so a software reset that clears the bit, or a hardware reset that keeps it, shows within one cycle.

// File: rtl/umap_pkg.sv
package umap_pkg;
  typedef enum logic [1:0] {
    SRC_PROG = 2'd0,
    SRC_DATA = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_HOST = 2'd3
  } src_e;
endpackage

// File: rtl/umap_romctl.sv
module umap_romctl (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic rom_dis
);
  // only the hardware reset touches this bit; the software reset is not wired here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rom_dis <= 1'b0;
    else if (we) rom_dis <= wdata;
  end
endmodule

// File: rtl/umap_region.sv
module umap_region
  import umap_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BANK_LG2   = 13,
  parameter int N_DA       = 8,
  parameter int N_SA       = 8,
  parameter int MMR_BYTES  = 192,
  parameter int HOST_BANKS = 4,
  parameter int ROM_LG2    = 16,
  parameter int OFF_W      = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  src_e              src,
  input  logic              rom_dis,
  output logic [N_DA-1:0]   da_sel,
  output logic [N_SA-1:0]   sa_sel,
  output logic              rom_sel,
  output logic              mmr_sel,
  output logic              ext_sel,
  output logic              host_err,
  output logic [OFF_W-1:0]  off
);
  localparam int DA_IDX_W = (N_DA > 1) ? $clog2(N_DA) : 1;
  localparam int SA_IDX_W = (N_SA > 1) ? $clog2(N_SA) : 1;
  localparam logic [ADDR_W-1:0] DA_END     = ADDR_W'(N_DA) << BANK_LG2;
  localparam logic [ADDR_W-1:0] SA_BASE    = DA_END;
  localparam logic [ADDR_W-1:0] SA_END     = SA_BASE + (ADDR_W'(N_SA) << BANK_LG2);
  localparam logic [ADDR_W-1:0] HOST_LIMIT = ADDR_W'(HOST_BANKS) << BANK_LG2;
  localparam logic [ADDR_W-1:0] MMR_END    = ADDR_W'(MMR_BYTES);
  localparam logic [ADDR_W-1:0] ROM_BASE   = ~((ADDR_W'(1) << ROM_LG2) - ADDR_W'(1));

  logic in_da, in_sa, in_mmr, rom_win, rom_hit;
  logic [ADDR_W-1:0]   sa_rel;
  logic [DA_IDX_W-1:0] da_idx;
  logic [SA_IDX_W-1:0] sa_idx;

  always_comb begin
    host_err = (src == SRC_HOST) && (addr >= HOST_LIMIT);
    in_mmr   = !host_err && (addr < MMR_END);
    in_da    = !host_err && !in_mmr && (addr < DA_END);
    in_sa    = !host_err && (addr >= SA_BASE) && (addr < SA_END);
    rom_win  = (addr >= ROM_BASE);
    rom_hit  = !host_err && rom_win && !rom_dis;
    sa_rel   = addr - SA_BASE;
    da_idx   = addr[BANK_LG2 +: DA_IDX_W];
    sa_idx   = sa_rel[BANK_LG2 +: SA_IDX_W];
    rom_sel  = rom_hit;
    mmr_sel  = in_mmr;
    ext_sel  = !host_err && !in_mmr && !in_da && !in_sa && !rom_hit;
    if (in_mmr || in_da || in_sa) off = OFF_W'(addr[BANK_LG2-1:0]);
    else if (rom_hit)             off = OFF_W'(addr[ROM_LG2-1:0]);
    else                          off = '0;
  end

  for (genvar g = 0; g < N_DA; g++) begin : g_da
    assign da_sel[g] = in_da && (da_idx == DA_IDX_W'(g));
  end
  for (genvar g = 0; g < N_SA; g++) begin : g_sa
    assign sa_sel[g] = in_sa && (sa_idx == SA_IDX_W'(g));
  end
endmodule

// File: rtl/umap_stage.sv
module umap_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (flush)          out_valid <= 1'b0;
      else if (take)      out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (take && !flush) out_data <= in_data;
    end
  end
endmodule

// File: rtl/umap_decode.sv
module umap_decode
  import umap_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BANK_LG2   = 13,
  parameter int N_DA       = 8,
  parameter int N_SA       = 8,
  parameter int MMR_BYTES  = 192,
  parameter int HOST_BANKS = 4,
  parameter int ROM_LG2    = 16,
  parameter int OFF_W      = (ROM_LG2 > BANK_LG2) ? ROM_LG2 : BANK_LG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              rom_dis_we,
  input  logic              rom_dis_wdata,
  output logic              rom_dis,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_src,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [N_DA-1:0]   rsp_daram_sel,
  output logic [N_SA-1:0]   rsp_saram_sel,
  output logic              rsp_rom_sel,
  output logic              rsp_mmr_sel,
  output logic              rsp_ext_sel,
  output logic              rsp_host_err,
  output logic [OFF_W-1:0]  rsp_offset
);
  localparam int PAY_W = N_DA + N_SA + 4 + OFF_W;

  logic [N_DA-1:0]  d_da;
  logic [N_SA-1:0]  d_sa;
  logic             d_rom, d_mmr, d_ext, d_err;
  logic [OFF_W-1:0] d_off;
  logic [PAY_W-1:0] pay_in, pay_out;

  umap_romctl i_romctl (
    .clk(clk), .rst_n(rst_n), .we(rom_dis_we), .wdata(rom_dis_wdata), .rom_dis(rom_dis)
  );

  umap_region #(
    .ADDR_W(ADDR_W), .BANK_LG2(BANK_LG2), .N_DA(N_DA), .N_SA(N_SA),
    .MMR_BYTES(MMR_BYTES), .HOST_BANKS(HOST_BANKS), .ROM_LG2(ROM_LG2), .OFF_W(OFF_W)
  ) i_region (
    .addr(req_addr), .src(src_e'(req_src)), .rom_dis(rom_dis),
    .da_sel(d_da), .sa_sel(d_sa), .rom_sel(d_rom), .mmr_sel(d_mmr),
    .ext_sel(d_ext), .host_err(d_err), .off(d_off)
  );

  assign pay_in = {d_da, d_sa, d_rom, d_mmr, d_ext, d_err, d_off};

  umap_stage #(.W(PAY_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .flush(sw_reset),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_daram_sel, rsp_saram_sel, rsp_rom_sel, rsp_mmr_sel,
          rsp_ext_sel, rsp_host_err, rsp_offset} = pay_out;
endmodule

// File: rtl/umap_decode_chk.sv
module umap_decode_chk #(
  parameter int N_DA      = 8,
  parameter int N_SA      = 8,
  parameter int MMR_BYTES = 192,
  parameter int OFF_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset,
  input logic             rom_dis_we,
  input logic             rom_dis,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [N_DA-1:0]  rsp_daram_sel,
  input logic [N_SA-1:0]  rsp_saram_sel,
  input logic             rsp_rom_sel,
  input logic             rsp_mmr_sel,
  input logic             rsp_ext_sel,
  input logic             rsp_host_err,
  input logic [OFF_W-1:0] rsp_offset
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_daram_sel, rsp_saram_sel, rsp_rom_sel,
                           rsp_mmr_sel, rsp_ext_sel, rsp_host_err})); // R9

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_host_err) |-> (rsp_daram_sel == '0 && rsp_saram_sel == '0 &&
      !rsp_rom_sel && !rsp_mmr_sel && !rsp_ext_sel && rsp_offset == '0)); // R8

  AST_MMR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mmr_sel) |-> (rsp_offset < OFF_W'(MMR_BYTES))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || sw_reset)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_daram_sel) &&
      $stable(rsp_saram_sel) && $stable(rsp_rom_sel) && $stable(rsp_mmr_sel) &&
      $stable(rsp_ext_sel) && $stable(rsp_host_err) && $stable(rsp_offset))); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10

  AST_ROMDIS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rom_dis_we) |-> $stable(rom_dis)); // R7
endmodule

bind umap_decode umap_decode_chk #(
  .N_DA(N_DA), .N_SA(N_SA), .MMR_BYTES(MMR_BYTES), .OFF_W(OFF_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .rom_dis_we(rom_dis_we),
  .rom_dis(rom_dis), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_daram_sel(rsp_daram_sel), .rsp_saram_sel(rsp_saram_sel),
  .rsp_rom_sel(rsp_rom_sel), .rsp_mmr_sel(rsp_mmr_sel), .rsp_ext_sel(rsp_ext_sel),
  .rsp_host_err(rsp_host_err), .rsp_offset(rsp_offset)
);

// File: tb/test_umap_decode.sv
`timescale 1ns/1ps
module test_umap_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_reset = 1'b0, rom_dis_we = 1'b0, rom_dis_wdata = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_src = '0;
  logic rom_dis, req_ready, rsp_valid;
  logic [7:0] rsp_daram_sel, rsp_saram_sel;
  logic rsp_rom_sel, rsp_mmr_sel, rsp_ext_sel, rsp_host_err;
  logic [15:0] rsp_offset;

  always #5 clk = ~clk;

  umap_decode i_umap_decode (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .rom_dis_we(rom_dis_we),
    .rom_dis_wdata(rom_dis_wdata), .rom_dis(rom_dis), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_daram_sel(rsp_daram_sel),
    .rsp_saram_sel(rsp_saram_sel), .rsp_rom_sel(rsp_rom_sel), .rsp_mmr_sel(rsp_mmr_sel),
    .rsp_ext_sel(rsp_ext_sel), .rsp_host_err(rsp_host_err), .rsp_offset(rsp_offset)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: behavioural decode over integer ranges
  bit          m_valid = 0, m_romdis = 0;
  logic [35:0] m_pay = '0;
  string       m_tag = "R10";

  function automatic void ref_decode(input int a, input int s, input bit rd,
                                     output logic [35:0] p, output string tag);
    logic [7:0] da = '0, sa = '0;
    bit rom = 0, mmr = 0, ext = 0, err = 0;
    int off = 0;
    if (s == 3 && a >= 'h8000) begin err = 1; tag = "R8"; end
    else if (a < 192) begin mmr = 1; off = a; tag = "R2"; end
    else if (a < 'h10000) begin da[a / 8192] = 1'b1; off = a % 8192; tag = "R1"; end
    else if (a < 'h20000) begin sa[(a - 'h10000) / 8192] = 1'b1; off = a % 8192; tag = "R3"; end
    else if (a >= 'hFF0000) begin
      tag = "R4";
      if (!rd) begin rom = 1; off = a - 'hFF0000; end
      else ext = 1;
    end
    else begin ext = 1; tag = "R5"; end
    p = {da, sa, rom, mmr, ext, err, 16'(off)};
  endfunction

  always @(negedge rst_n) begin m_valid = 0; m_romdis = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_romdis = 0;
    end else begin
      bit acc;
      logic [35:0] p;
      string t;
      acc = req_valid && (!m_valid || rsp_ready);
      ref_decode(int'(req_addr), int'(req_src), m_romdis, p, t);
      if (sw_reset) m_valid = 0;
      else if (acc) begin m_valid = 1; m_pay = p; m_tag = t; end
      else if (rsp_ready) m_valid = 0;
      if (rom_dis_we) m_romdis = rom_dis_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid == m_valid, "R10", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
      chk(req_ready == (!m_valid || rsp_ready), "R10", "req_ready",
          64'(req_ready), 64'(!m_valid || rsp_ready));
      chk(rom_dis == m_romdis, "R6", "rom_dis", 64'(rom_dis), 64'(m_romdis));
      if (m_valid) begin
        logic [35:0] act;
        act = {rsp_daram_sel, rsp_saram_sel, rsp_rom_sel, rsp_mmr_sel,
               rsp_ext_sel, rsp_host_err, rsp_offset};
        chk(act == m_pay, m_tag, "decode", 64'(act), 64'(m_pay));
        chk($countones(act[35:16]) == 1, "R9", "target count",
            64'($countones(act[35:16])), 64'd1);
      end
    end
  end

  task automatic step(input bit v, input logic [23:0] a, input logic [1:0] s,
                      input bit rdy, input bit we, input bit wd, input bit swr);
    @(posedge clk); #2;
    req_valid = v; req_addr = a; req_src = s; rsp_ready = rdy;
    rom_dis_we = we; rom_dis_wdata = wd; sw_reset = swr;
  endtask

  task automatic req(input logic [23:0] a, input logic [1:0] s);
    step(1, a, s, 1, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, '0, 0, 1, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rom_dis == 1'b0 && rsp_valid == 1'b0, "R6", "hard reset state",
        64'({rom_dis, rsp_valid}), 64'd0);
    #1 rst_n = 1'b1;
    // R2 / R1 boundaries, each requester
    for (int s = 0; s < 4; s++) begin
      req(24'h000000, 2'(s)); req(24'h0000BF, 2'(s)); req(24'h0000C0, 2'(s));
      req(24'h001FFF, 2'(s)); req(24'h002000, 2'(s)); req(24'h007FFF, 2'(s));
      req(24'h008000, 2'(s)); req(24'h00FFFF, 2'(s));
      // R3, R4, R5
      req(24'h010000, 2'(s)); req(24'h01E123, 2'(s)); req(24'h01FFFF, 2'(s));
      req(24'h020000, 2'(s)); req(24'h800000, 2'(s)); req(24'hFEFFFF, 2'(s));
      req(24'hFF0000, 2'(s)); req(24'hFFFFFF, 2'(s));
    end
    idle();
    // R6: write disable and request ROM in same cycle -> old value used
    step(1, 24'hFF1234, 0, 1, 1, 1, 0);
    req(24'hFF1234, 1);
    idle();
    // R7: software reset keeps the bit and drops a concurrent request
    step(1, 24'h000100, 0, 1, 0, 0, 1);
    idle();
    @(negedge clk);
    chk(rom_dis == 1'b1, "R7", "rom_dis after sw_reset", 64'(rom_dis), 64'd1);
    req(24'hFF0010, 2);
    idle();
    // R6: hardware reset clears the bit
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #1;
    chk(rom_dis == 1'b0, "R6", "rom_dis after hard reset", 64'(rom_dis), 64'd0);
    #1 rst_n = 1'b1;
    req(24'hFF0010, 3); req(24'hFF0010, 0);
    // R10: stall holds the response
    step(1, 24'h004444, 1, 0, 0, 0, 0);
    step(1, 24'h014444, 1, 0, 0, 0, 0);
    step(1, 24'h014444, 1, 0, 0, 0, 0);
    step(0, 24'h0, 0, 1, 0, 0, 0);
    idle();
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] a;
      int r;
      r = $urandom % 6;
      case (r)
        0: a = 24'($urandom % 256);
        1: a = 24'($urandom % 'h10000);
        2: a = 24'h010000 + 24'($urandom % 'h10000);
        3: a = 24'hFF0000 + 24'($urandom % 'h10000);
        4: a = 24'($urandom);
        default: a = 24'h006000 + 24'($urandom % 'h4000);
      endcase
      step($urandom % 4 != 0, a, 2'($urandom), $urandom % 3 != 0,
           $urandom % 16 == 0, 1'($urandom), $urandom % 64 == 0);
    end
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule